// File: doc/BRIEF.md
# PCI Interrupt Steering Router

This block gathers the level-sensitive INTx pins of a small group of PCI device slots and delivers them to the sixteen inputs of a legacy interrupt controller. It works in three steps. First, each slot's four pins are rotated by slot number onto four shared PCI interrupt lines (lines 0 to 3), so that single-function devices that all use their first pin still spread across the lines. Next, a byte-wide steering register for each line picks which legacy interrupt number the line drives, or leaves the line unrouted. Last, every legacy output is the OR of all lines steered to it, so lines that share a target merge onto one input.

Software reaches the four steering bytes through a simple byte read/write port. Writes take effect at the clock edge. Reads are combinational and return the stored byte. The legacy output vector is registered. The controller in front of this block handles edge detection and prioritisation.

Top module: `irq_steer_router`

## Requirements
- R1: Pin p (0 to 3) of slot s (slots numbered 1 to 4) feeds interrupt line (p + s - 1) mod 4. Pin p of slot s is input bit `slot_irq[4*(s-1)+p]`.
- R2: The steering byte for line n sits at address 0x60+n. A write there stores all 8 bits, and a read returns the stored byte unchanged, bit 7 included.
- R3: During and after reset, all four steering bytes read 0x80 and `legacy_irq` is all zeros.
- R4: A steering byte below 16 steers its line to the legacy output of that number. A byte of 16 or more (for example 0x10, 0x80, 0xFF) leaves the line unrouted.
- R5: Each legacy output is the OR of the levels of every interrupt line whose steering byte equals that output's number.
- R6: An interrupt line's level is the OR of all slot pins that rotate onto it. With no slot pin high, every legacy output is low one clock later.
- R7: `legacy_irq` reflects the slot inputs and steering bytes as they stood just before the previous rising clock edge, which gives exactly one clock of latency for either kind of change.
- R8: Writes to addresses outside 0x60 to 0x63 change no steering byte. Reads from such addresses return 0x00.
- R9: A legacy output that no interrupt line targets stays low whatever the slot inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the steering-byte port |
| cfg_addr | input | 8 | Byte address for reads and writes |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| slot_irq | input | 16 | Slot INTx levels, bit 4*(slot-1)+pin |
| legacy_irq | output | 16 | Registered legacy interrupt controller inputs |

## Verification
The hardest case to reach is a legacy output fed by several lines at once. It needs two or more steering bytes set to the same number, plus slot pins whose rotations land on different lines, because pins that land on the same line merge before steering and never exercise the shared target. The stimulus first points all four lines at one number. It then raises one pin from each of four slots chosen so that each rotates onto a different line, and drops them one at a time. Last, it reprograms a steering byte while pins are held, so that the one-clock latency of a routing change is seen apart from the latency of an input change.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
    // Number of shared PCI interrupt lines; fixed by the rotation rule.
    localparam int LINE_CNT   = 4;
    localparam int PINS_PER_SLOT = 4;
    localparam int ROUTE_W    = 8;

    typedef logic [ROUTE_W-1:0] route_t;
    typedef logic [LINE_CNT-1:0][ROUTE_W-1:0] route_bank_t;

    // Line driven by a given pin of a given slot number.
    function automatic int line_of(input int pin, input int slot_no);
        return (pin + slot_no + LINE_CNT - 1) % LINE_CNT;
    endfunction
endpackage

// File: rtl/slot_swizzle.sv
module slot_swizzle
    import irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 1,
    localparam int PIN_W     = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic [PIN_W-1:0]    slot_irq,
    output logic [LINE_CNT-1:0] line_lvl
);
    // Each line is the OR of all pins whose rotation lands on it.
    always_comb begin
        line_lvl = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int p = 0; p < PINS_PER_SLOT; p++) begin
                if (slot_irq[s*PINS_PER_SLOT + p]) begin
                    line_lvl[line_of(p, s + FIRST_SLOT)] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/route_regfile.sv
module route_regfile
    import irq_steer_pkg::*;
#(
    parameter int     ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
    parameter route_t RESET_ROUTE = 8'h80,
    localparam int    IDX_W       = $clog2(LINE_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  route_t            cfg_wdata,
    output route_t            cfg_rdata,
    output route_bank_t       routes
);
    logic [ADDR_W-1:0] offset;
    logic              in_win;
    logic [IDX_W-1:0]  idx;

    assign offset = cfg_addr - BASE_ADDR;
    assign in_win = (cfg_addr >= BASE_ADDR) && (offset < ADDR_W'(LINE_CNT));
    assign idx    = offset[IDX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            routes <= {LINE_CNT{RESET_ROUTE}};
        end else if (cfg_wr && in_win) begin
            routes[idx] <= cfg_wdata;
        end
    end

    assign cfg_rdata = in_win ? routes[idx] : '0;

    // R2
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && in_win) |=> (routes[$past(idx)] == $past(cfg_wdata)));

    // R8
    stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !in_win) |=> $stable(routes));

    // R3
    rst_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (routes == {LINE_CNT{RESET_ROUTE}}));
endmodule

// File: rtl/steer_merge.sv
module steer_merge
    import irq_steer_pkg::*;
#(
    parameter int NUM_LEGACY = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  route_bank_t           routes,
    input  logic [LINE_CNT-1:0]   line_lvl,
    output logic [NUM_LEGACY-1:0] legacy_irq
);
    logic [LINE_CNT-1:0]   routed;
    logic [NUM_LEGACY-1:0] merged;

    // A line takes part only when its byte names an existing output.
    always_comb begin
        for (int n = 0; n < LINE_CNT; n++) begin
            routed[n] = (routes[n] < route_t'(NUM_LEGACY));
        end
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < NUM_LEGACY; i++) begin
            for (int n = 0; n < LINE_CNT; n++) begin
                if (routed[n] && line_lvl[n] && (routes[n] == route_t'(i))) begin
                    merged[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) legacy_irq <= '0;
        else        legacy_irq <= merged;
    end

    // R4
    none_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (routed == '0) |=> (legacy_irq == '0));

    // R5
    active_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(legacy_irq) <= LINE_CNT);
endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
    import irq_steer_pkg::*;
#(
    parameter int NUM_SLOTS  = 4,
    parameter int FIRST_SLOT = 1,
    parameter int NUM_LEGACY = 16,
    localparam int PIN_W     = NUM_SLOTS * PINS_PER_SLOT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    input  logic [PIN_W-1:0]      slot_irq,
    output logic [NUM_LEGACY-1:0] legacy_irq
);
    route_bank_t         routes;
    logic [LINE_CNT-1:0] line_lvl;

    slot_swizzle #(
        .NUM_SLOTS (NUM_SLOTS),
        .FIRST_SLOT(FIRST_SLOT)
    ) u_swz (
        .slot_irq(slot_irq),
        .line_lvl(line_lvl)
    );

    route_regfile #(
        .ADDR_W     (8),
        .BASE_ADDR  (8'h60),
        .RESET_ROUTE(8'h80)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .routes   (routes)
    );

    steer_merge #(
        .NUM_LEGACY(NUM_LEGACY)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .routes    (routes),
        .line_lvl  (line_lvl),
        .legacy_irq(legacy_irq)
    );

    // R6
    quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_irq == '0) |=> (legacy_irq == '0));
endmodule

// File: tb/sim_irq_steer_router.sv
module sim_irq_steer_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [15:0] slot_irq = '0;
    logic [15:0] legacy_irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    string cur_req = "R3";

    // Reference model state
    int          ref_route [4];
    logic [15:0] ref_out;

    irq_steer_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .slot_irq(slot_irq), .legacy_irq(legacy_irq)
    );

    always #4 clk = ~clk;  // 125 MHz

    function automatic logic [15:0] model_out(input logic [15:0] pins);
        logic [15:0] res = '0;
        bit lines [4] = '{0, 0, 0, 0};
        for (int slot = 1; slot <= 4; slot++)
            for (int pin = 0; pin < 4; pin++)
                if (pins[4*(slot-1)+pin]) lines[(pin + slot - 1) % 4] = 1;
        for (int n = 0; n < 4; n++)
            if (lines[n] && ref_route[n] < 16) res[ref_route[n]] = 1'b1;
        return res;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a >= 8'h60 && a <= 8'h63) return 8'(ref_route[a - 8'h60]);
        return 8'h00;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) ref_route[n] = 'h80;
            ref_out = '0;
        end else begin
            ref_out = model_out(slot_irq);
            if (cfg_wr && cfg_addr >= 8'h60 && cfg_addr <= 8'h63)
                ref_route[cfg_addr - 8'h60] = int'(cfg_wdata);
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (legacy_irq !== ref_out) begin
                n_bad++;
                $display("FAIL %s legacy_irq actual=%h expected=%h", cur_req, legacy_irq, ref_out);
            end
            n_cmp++;
            if (cfg_rdata !== model_read(cfg_addr)) begin
                n_bad++;
                $display("FAIL %s cfg_rdata[%h] actual=%h expected=%h", cur_req, cfg_addr,
                         cfg_rdata, model_read(cfg_addr));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(posedge clk); #2;
        cfg_addr = a;
        @(posedge clk); #2;
    endtask

    task automatic pins(input logic [15:0] v);
        @(posedge clk); #2;
        slot_irq = v;
        @(posedge clk); #2;
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R3: reset state, including pins held high during reset
        slot_irq = 16'hFFFF;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        for (int a = 'h60; a <= 'h63; a++) rd(8'(a));
        pins(16'h0000);

        // R2: full byte readback, bit 7 included
        cur_req = "R2";
        wr(8'h60, 8'h85); rd(8'h60);
        wr(8'h61, 8'h3C); rd(8'h61);
        wr(8'h62, 8'hFF); rd(8'h62);
        wr(8'h63, 8'h00); rd(8'h63);

        // R1 and R6: line n -> output n+3, sweep each pin alone
        cur_req = "R1";
        for (int n = 0; n < 4; n++) wr(8'(8'h60 + n), 8'(n + 3));
        for (int b = 0; b < 16; b++) pins(16'(1) << b);
        cur_req = "R6";
        pins(16'h1248); pins(16'h000F); pins(16'hF000); pins(16'h0000);

        // R4: boundary values of the steering byte
        cur_req = "R4";
        wr(8'h60, 8'h0F); pins(16'h0001);
        wr(8'h60, 8'h10); pins(16'h0001);
        wr(8'h60, 8'hFF); pins(16'h0001);
        wr(8'h60, 8'h00); pins(16'h0001);

        // R5: all lines share one target, pins on distinct lines
        cur_req = "R5";
        for (int n = 0; n < 4; n++) wr(8'(8'h60 + n), 8'h09);
        pins(16'h1111); pins(16'h1110); pins(16'h1100); pins(16'h1000); pins(16'h0000);
        wr(8'h62, 8'h02);
        pins(16'h0404); pins(16'h0400);

        // R7: steering change while pins are held
        cur_req = "R7";
        @(posedge clk); #2 slot_irq = 16'h0001;
        wr(8'h60, 8'h0E); wr(8'h60, 8'h05); wr(8'h60, 8'h90);
        rd(8'h60);

        // R8: writes outside the window are dropped, reads there give zero
        cur_req = "R8";
        wr(8'h64, 8'h01); wr(8'h5F, 8'h01); wr(8'hE0, 8'h01); wr(8'h00, 8'h01);
        for (int a = 'h5F; a <= 'h64; a++) rd(8'(a));
        rd(8'hFF);

        // R9: random patterns; untargeted outputs must stay low
        cur_req = "R9";
        wr(8'h60, 8'h01); wr(8'h61, 8'h07); wr(8'h62, 8'h07); wr(8'h63, 8'h20);
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #2;
            slot_irq = 16'($urandom);
            if (k % 10 == 0) begin
                cfg_wr = 1'b1;
                cfg_addr = 8'(8'h60 + ($urandom % 6));
                cfg_wdata = 8'($urandom % 24);
                @(posedge clk); #2 cfg_wr = 1'b0;
            end
        end
        pins(16'h0000);
        finish_run();
    end
endmodule